// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block derives the serial clock for a two-wire bus master from the system clock. A 5-bit rate code selects one of 31 fixed integer divisors, from 39 to 6147 system clocks per bit. A duty option chooses between a roughly even high/low split and a long-high split in which the line stays released for about three quarters of the period. The block drives the line low through an open-drain style request, `scl_pull_low`, and reads the resolved wired-AND level back on `scl_in`. Two strobes mark the points where the data shifter outside this block may change its data (start of each low phase) and sample it (first high cycle).

The generator follows the other devices on the line. It holds its high-phase count until the line actually reads high, so any device that holds the clock low stretches the low phase. It starts a new low phase as soon as another master pulls the line low during a high phase, so the bus high time is the shortest one among all masters. A byte marker counts the sample points of each byte: eight, or nine when the acknowledge clock is enabled. Code zero is forbidden and keeps the generator idle with the line released.

Top module: `scl_rate_gen`

## Requirements
- R1: For rate codes 1 to 31 the undisturbed clock period in system clocks is, in code order: 39, 45, 51, 63, 75, 87, 99, 123, 147, 171, 195, 243, 291, 339, 387, 483, 579, 675, 771, 963, 1155, 1347, 1539, 1923, 2307, 2691, 3075, 3843, 4611, 5379, 6147.
- R2: While the rate code is 0, the line is released one cycle later and stays released, and no strobe or byte marker is produced, even with `run` high.
- R3: With `asym_en` low the released (high) time is floor(P/2) cycles and the low time is P minus that, where P is the period of R1.
- R4: With `asym_en` high the high time is floor(3P/4) cycles and the low time is P minus that.
- R5: With `asym_en` high, codes 1, 2 and 3 give the timing of code 4 (P = 63, high 47, low 16).
- R6: After its own low time the block releases the line, and its high-time count starts only in the first cycle in which `scl_in` reads high. An external low therefore lengthens the low phase and leaves the high time unchanged.
- R7: If `scl_in` reads low after at least one high cycle has been counted, the high phase ends and a full low phase starts on the next cycle.
- R8: `setup_stb` is high only in the first cycle of each low phase, and `sample_stb` is high only in the first cycle of each high phase in which `scl_in` reads high. Each strobe occurs once per period.
- R9: `byte_end` coincides with every 8th `sample_stb` when `ack_en` is low, and with every 9th when it is high. The count restarts whenever the generator goes idle.
- R10: When `run` is low, the line is released in the next cycle and the generator stays idle. When `run` rises with a valid code, the low phase begins on the next cycle.
- R11: The rate code, duty option and acknowledge option are captured when each low phase starts. A change in the middle of a period takes effect from the following period, except that code 0 stops the generator at once (R2).
- R12: During and directly after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Enables clock generation |
| rate_code | input | 5 | Divisor select; 0 is forbidden |
| asym_en | input | 1 | Selects the three-quarter-high duty mode |
| ack_en | input | 1 | Adds a ninth (acknowledge) clock to each byte |
| scl_in | input | 1 | Resolved clock line level, already synchronised |
| scl_pull_low | output | 1 | Request to drive the clock line low |
| setup_stb | output | 1 | First cycle of a low phase: data may change |
| sample_stb | output | 1 | First high cycle: data may be sampled |
| byte_end | output | 1 | Marks the last sample point of a byte |

## Verification
A corrupted phase counter or captured length shows within one clock period as a low or high run on the line that differs from the value expected for the code, and the bench measures both runs for every code and mode it uses. A wrong phase state shows up at the next transition: a strobe misses its phase, the line is pulled while idle, or the generator fails to react to an external low. A faulty sample tally shifts `byte_end` by at least one sample point within the first byte after start.

// File: rtl/scl_rate_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and the divisor rule of the serial clock rate generator.
// Assumes a 5-bit rate code; every period fits in PER_W bits.
package scl_rate_pkg;

    localparam int CODE_W   = 5;
    localparam int PER_W    = 13;
    localparam int ASYM_MIN = 4;   // smallest code allowed in long-high duty mode

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Divisor for a code: codes 1..3 step by 6 from 39; from code 4 on,
    // groups of four codes, each group doubling the base and the step.
    function automatic logic [PER_W-1:0] rate_divisor(input logic [CODE_W-1:0] code);
        logic [31:0] grp;
        logic [31:0] idx;
        logic [31:0] val;
        if (code == '0) begin
            val = 32'd0;
        end else if (code < CODE_W'(ASYM_MIN)) begin
            val = 32'd33 + 32'd6 * 32'(code);
        end else begin
            grp = 32'(code - CODE_W'(ASYM_MIN)) >> 2;
            idx = 32'(code - CODE_W'(ASYM_MIN)) & 32'd3;
            val = 32'd3 + (32'd60 << grp) + ((32'd12 << grp) * idx);
        end
        return PER_W'(val);
    endfunction

endpackage

// File: rtl/scl_timing_calc.sv
`timescale 1ns/1ps
// Turns rate code and duty option into low and high phase lengths.
// Purely combinational; in long-high mode, codes below ASYM_MIN are raised to ASYM_MIN.
module scl_timing_calc
    import scl_rate_pkg::*;
#(
    parameter int CNT_W = PER_W
) (
    input  logic [CODE_W-1:0] rate_code,
    input  logic              asym_en,
    output logic              code_ok,
    output logic [CNT_W-1:0]  low_len,
    output logic [CNT_W-1:0]  high_len
);
    localparam int PROD_W = PER_W + 2;

    logic [CODE_W-1:0] eff_code;
    logic [PER_W-1:0]  period;
    logic [PROD_W-1:0] triple;
    logic [PER_W-1:0]  hi_sel;

    // Code validity and substitution of the codes banned in long-high mode.
    always_comb begin
        code_ok  = (rate_code != '0);
        eff_code = (asym_en && code_ok && (rate_code < CODE_W'(ASYM_MIN)))
                   ? CODE_W'(ASYM_MIN) : rate_code;
    end

    // Period lookup and split into high and low parts.
    always_comb begin
        period   = rate_divisor(eff_code);
        triple   = PROD_W'(period) * PROD_W'(3);
        hi_sel   = asym_en ? PER_W'(triple >> 2) : (period >> 1);
        high_len = CNT_W'(hi_sel);
        low_len  = CNT_W'(period - hi_sel);
    end
endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
// Low/high phase sequencer with wired-AND clock synchronisation.
// Assumes scl_in is already synchronised to clk and both lengths are at least 2.
module scl_phase_fsm
    import scl_rate_pkg::*;
#(
    parameter int CNT_W = PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    input  logic             ack_in,
    input  logic             scl_in,
    output logic             pull_low,
    output logic             setup_stb,
    output logic             sample_stb,
    output logic             active,
    output logic             ack_q
);
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] low_q;
    logic [CNT_W-1:0] high_q;
    logic             enter_low;
    logic             low_done;

    // Decide when a new low phase begins and when the current one ends.
    always_comb begin
        low_done  = (phase == PH_LOW) && (cnt == low_q - CNT_W'(1));
        enter_low = 1'b0;
        unique case (phase)
            PH_IDLE: enter_low = 1'b1;
            PH_HIGH: enter_low = scl_in ? (cnt == high_q - CNT_W'(1)) : (cnt != '0);
            default: enter_low = 1'b0;
        endcase
    end

    // Phase state, cycle counter and per-period capture of the settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            low_q  <= '0;
            high_q <= '0;
            ack_q  <= 1'b0;
        end else if (!go) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (enter_low) begin
            phase  <= PH_LOW;
            cnt    <= '0;
            low_q  <= low_len;
            high_q <= high_len;
            ack_q  <= ack_in;
        end else if (low_done) begin
            phase <= PH_HIGH;
            cnt   <= '0;
        end else if (phase == PH_LOW || (phase == PH_HIGH && scl_in)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Line request and phase strobes.
    always_comb begin
        pull_low   = (phase == PH_LOW);
        setup_stb  = (phase == PH_LOW) && (cnt == '0);
        sample_stb = (phase == PH_HIGH) && (cnt == '0) && scl_in;
        active     = (phase != PH_IDLE);
    end
endmodule

// File: rtl/scl_bit_tally.sv
`timescale 1ns/1ps
// Counts sample points and marks the last one of each byte.
// Assumes ack_q is stable within a period; clears while the generator idles.
module scl_bit_tally #(
    parameter int BYTE_BITS = 8,
    localparam int TALLY_W  = $clog2(BYTE_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sample_stb,
    input  logic ack_q,
    output logic byte_end
);
    logic [TALLY_W-1:0] tally;
    logic [TALLY_W-1:0] last_idx;

    // Index of the final sample point of a byte.
    always_comb begin
        last_idx = ack_q ? TALLY_W'(BYTE_BITS) : TALLY_W'(BYTE_BITS - 1);
        byte_end = sample_stb && (tally == last_idx);
    end

    // Sample-point counter with wrap at the end of a byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            tally <= '0;
        end else if (sample_stb) begin
            tally <= byte_end ? '0 : tally + TALLY_W'(1);
        end
    end
endmodule

// File: rtl/scl_rate_gen.sv
`timescale 1ns/1ps
// Serial clock rate generator: code-selected period, duty option, stretching
// and synchronisation on a wired-AND line, setup/sample strobes, byte marker.
// Assumes scl_in is the synchronised resolved line level.
module scl_rate_gen
    import scl_rate_pkg::*;
#(
    parameter int CNT_W     = PER_W,
    parameter int BYTE_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              asym_en,
    input  logic              ack_en,
    input  logic              scl_in,
    output logic              scl_pull_low,
    output logic              setup_stb,
    output logic              sample_stb,
    output logic              byte_end
);
    logic             code_ok;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] high_len;
    logic             go;
    logic             active;
    logic             ack_q;

    // Generator runs only with run high and a permitted code.
    assign go = run && code_ok;

    scl_timing_calc #(.CNT_W(CNT_W)) u_calc (
        .rate_code (rate_code),
        .asym_en   (asym_en),
        .code_ok   (code_ok),
        .low_len   (low_len),
        .high_len  (high_len)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .low_len    (low_len),
        .high_len   (high_len),
        .ack_in     (ack_en),
        .scl_in     (scl_in),
        .pull_low   (scl_pull_low),
        .setup_stb  (setup_stb),
        .sample_stb (sample_stb),
        .active     (active),
        .ack_q      (ack_q)
    );

    scl_bit_tally #(.BYTE_BITS(BYTE_BITS)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .sample_stb (sample_stb),
        .ack_q      (ack_q),
        .byte_end   (byte_end)
    );
endmodule

// File: rtl/scl_rate_gen_chk.sv
`timescale 1ns/1ps
// Port-level property checker for scl_rate_gen, attached by bind.
module scl_rate_gen_chk #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [CODE_W-1:0] rate_code,
    input logic              scl_in,
    input logic              scl_pull_low,
    input logic              setup_stb,
    input logic              sample_stb,
    input logic              byte_end
);
    a_r2_forbidden_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == '0) |=> (!scl_pull_low && !setup_stb && !sample_stb));

    a_r10_run_release: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!scl_pull_low && !setup_stb && !sample_stb));

    a_r8_setup_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        setup_stb |-> scl_pull_low);

    a_r8_low_starts_with_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> setup_stb);

    a_r8_sample_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (scl_in && !scl_pull_low));

    a_r8_single_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    a_r8_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({setup_stb, sample_stb}));

    a_r9_byte_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        byte_end |-> sample_stb);
endmodule

bind scl_rate_gen scl_rate_gen_chk #(.CODE_W(scl_rate_pkg::CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .rate_code    (rate_code),
    .scl_in       (scl_in),
    .scl_pull_low (scl_pull_low),
    .setup_stb    (setup_stb),
    .sample_stb   (sample_stb),
    .byte_end     (byte_end)
);

// File: tb/sim_scl_rate_gen.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, line modelled as wired-AND with an external device.
module sim_scl_rate_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       run;
    logic [4:0] rate_code;
    logic       asym_en;
    logic       ack_en;
    logic       ext_low;
    logic       scl_pull_low;
    logic       setup_stb;
    logic       sample_stb;
    logic       byte_end;
    logic       bus;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int div_tab [1:31] = '{39, 45, 51, 63, 75, 87, 99, 123, 147, 171, 195, 243, 291,
                           339, 387, 483, 579, 675, 771, 963, 1155, 1347, 1539, 1923,
                           2307, 2691, 3075, 3843, 4611, 5379, 6147};

    always #2 clk = ~clk;

    assign bus = !(scl_pull_low || ext_low);

    scl_rate_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .rate_code    (rate_code),
        .asym_en      (asym_en),
        .ack_en       (ack_en),
        .scl_in       (bus),
        .scl_pull_low (scl_pull_low),
        .setup_stb    (setup_stb),
        .sample_stb   (sample_stb),
        .byte_end     (byte_end)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_setup();
        while (!setup_stb) @(negedge clk);
    endtask

    // Counts low then high samples from the current negedge; ends on the next low.
    task automatic count_phases(output int lo, output int hi, output int nsu,
                                output int ns_lo, output int ns_hi);
        lo = 0; hi = 0; nsu = 0; ns_lo = 0; ns_hi = 0;
        while (!bus) begin
            lo++;
            if (setup_stb) nsu++;
            if (sample_stb) ns_lo++;
            @(negedge clk);
        end
        while (bus) begin
            hi++;
            if (sample_stb) ns_hi++;
            @(negedge clk);
        end
    endtask

    task automatic restart(input int code, input bit asym, input bit ack);
        run = 1'b0;
        @(negedge clk);
        rate_code = 5'(code);
        asym_en   = asym;
        ack_en    = ack;
        run       = 1'b1;
    endtask

    // R1, R3, R4, R5, R8: one undisturbed period for a code and duty mode.
    task automatic t_period(input string req, input int code, input bit asym, input int exp_code);
        int lo, hi, nsu, nsl, nsh, p, eh;
        p  = div_tab[exp_code];
        eh = asym ? (3 * p) / 4 : p / 2;
        restart(code, asym, 1'b0);
        wait_setup();
        count_phases(lo, hi, nsu, nsl, nsh);
        check(req, $sformatf("code %0d asym %0d period", code, asym), lo + hi, p);
        check(req, $sformatf("code %0d asym %0d high", code, asym), hi, eh);
        check("R8", "setup strobes per low", nsu, 1);
        check("R8", "sample strobes per high", nsh, 1);
        check("R8", "sample strobes in low", nsl, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run = 1'b1; rate_code = 5'd1; asym_en = 1'b0; ack_en = 1'b0; ext_low = 1'b0;
        repeat (4) @(negedge clk);
        check("R12", "pull during reset", int'(scl_pull_low), 0);
        check("R12", "strobes during reset", int'(setup_stb | sample_stb | byte_end), 0);
        run = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "outputs after reset", int'({scl_pull_low, setup_stb, sample_stb, byte_end}), 0);
    endtask

    // R2: forbidden code keeps the line released.
    task automatic t_forbidden();
        int act;
        restart(0, 1'b0, 1'b1);
        act = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (scl_pull_low || setup_stb || sample_stb || byte_end) act++;
        end
        check("R2", "activity with code 0", act, 0);
        restart(8, 1'b0, 1'b0);
        wait_setup();
        repeat (5) @(negedge clk);
        rate_code = 5'd0;
        @(negedge clk);
        check("R2", "release after switch to code 0", int'(scl_pull_low), 0);
    endtask

    // R6: external device holds the line past the own low time.
    task automatic t_stretch();
        int lo, hi, bad, ns;
        restart(1, 1'b0, 1'b0);
        wait_setup();
        ext_low = 1'b1;
        lo = 1; bad = 0;
        for (int k = 1; k < 30; k++) begin
            @(negedge clk);
            if (!bus) lo++;
            if (sample_stb) bad++;
        end
        @(posedge clk);
        #1 ext_low = 1'b0;
        @(negedge clk);
        hi = 0; ns = 0;
        while (bus) begin
            hi++;
            if (sample_stb) ns++;
            @(negedge clk);
        end
        check("R6", "stretched low length", lo, 30);
        check("R6", "sample strobes while held low", bad, 0);
        check("R6", "high after stretch", hi, 19);
        check("R6", "sample strobe after release", ns, 1);
    endtask

    // R7: another master pulls low during the high phase.
    task automatic t_sync();
        int lo, hi, nsu, nsl, nsh;
        restart(8, 1'b0, 1'b0);
        wait_setup();
        while (!bus) @(negedge clk);
        repeat (4) @(negedge clk);
        @(posedge clk);
        #1 ext_low = 1'b1;
        @(negedge clk);
        check("R7", "own pull during foreign low", int'(scl_pull_low), 0);
        @(posedge clk);
        #1 ext_low = 1'b0;
        @(negedge clk);
        check("R7", "setup right after foreign low", int'(setup_stb), 1);
        count_phases(lo, hi, nsu, nsl, nsh);
        check("R7", "low after sync", lo, 62);
        check("R7", "high after sync", hi, 61);
    endtask

    // R9: sample points per byte with and without acknowledge clock.
    task automatic t_bytes(input bit ack, input int exp);
        int n;
        restart(1, 1'b0, ack);
        for (int b = 0; b < 2; b++) begin
            n = 0;
            do begin
                @(negedge clk);
                if (sample_stb) n++;
            end while (!byte_end);
            check("R9", $sformatf("samples per byte ack %0d", ack), n, exp);
        end
    endtask

    // R10: run low releases the line and stays idle.
    task automatic t_run_drop();
        int act;
        restart(8, 1'b0, 1'b0);
        wait_setup();
        repeat (10) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check("R10", "release one cycle after run low", int'(scl_pull_low), 0);
        act = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (scl_pull_low || setup_stb || sample_stb) act++;
        end
        check("R10", "idle with run low", act, 0);
        run = 1'b1;
        @(negedge clk);
        check("R10", "low phase after run rises", int'(setup_stb), 1);
    endtask

    // R11: a code change mid-period applies from the next period.
    task automatic t_change();
        int lo, hi, nsu, nsl, nsh;
        restart(8, 1'b0, 1'b0);
        wait_setup();
        count_phases(lo, hi, nsu, nsl, nsh);
        rate_code = 5'd1;
        count_phases(lo, hi, nsu, nsl, nsh);
        check("R11", "period after mid-period change", lo + hi, 123);
        count_phases(lo, hi, nsu, nsl, nsh);
        check("R11", "period with new code", lo + hi, 39);
    endtask

    initial begin
        #(150000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_period("R1", 1, 1'b0, 1);
        t_period("R1", 2, 1'b0, 2);
        t_period("R1", 3, 1'b0, 3);
        t_period("R3", 4, 1'b0, 4);
        t_period("R1", 7, 1'b0, 7);
        t_period("R3", 12, 1'b0, 12);
        t_period("R1", 20, 1'b0, 20);
        t_period("R1", 31, 1'b0, 31);
        t_period("R4", 4, 1'b1, 4);
        t_period("R4", 9, 1'b1, 9);
        t_period("R4", 31, 1'b1, 31);
        t_period("R5", 1, 1'b1, 4);
        t_period("R5", 2, 1'b1, 4);
        t_period("R5", 3, 1'b1, 4);
        t_forbidden();
        t_stretch();
        t_sync();
        t_bytes(1'b0, 8);
        t_bytes(1'b1, 9);
        t_run_drop();
        t_change();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule